// File: doc/BRIEF.md
# Guarded Dual Stack Unit

This block holds the two stacks of one processor core: a data stack of signed words and a return-address stack. An instruction decoder outside the block presents a 3-bit operation code with a valid strobe and, for a literal, the value to push. The block updates both stacks on the next clock edge. It always shows the top entries and the depth of each stack.

Each operation first passes through a guard. The guard checks that the data stack holds enough operands and has room for the results, and does the same for the address stack. If the guard finds a fault, the operation writes nothing to either stack, and the block pulses a fault code for one cycle so that the core can raise an interrupt.

Recovery differs between the two stacks. A data-stack fault empties the data stack. An address-stack fault leaves the address pointer where it was. A synchronous clear empties both stacks, for use at core initialisation and image reload.

Top module: `tsg_unit`

## Requirements
- R1: After reset both depths are 0, fault_valid is 0, fault_code is 0, and every top output reads 0.
- R2: Opcode 1 (literal) pushes push_val onto the data stack and raises the data depth by one.
- R3: Opcode 2 (duplicate) pushes a copy of the data top, so the top two entries become equal.
- R4: Opcode 3 (drop) removes the data top. The entry below it becomes the new top.
- R5: Opcode 4 (swap) exchanges the top two data entries and leaves the depth unchanged.
- R6: Opcode 5 (to-address) moves the data top onto the address stack. The data depth falls by one and the address depth rises by one.
- R7: Opcode 6 (from-address) moves the address top onto the data stack. The address depth falls by one and the data depth rises by one.
- R8: Opcode 7 (depth query) pushes the data depth as it was before the operation, then the address depth. The address depth ends on top, and the data depth rises by two.
- R9: A data underflow (code 1) or data overflow (code 2) sets the data depth to 0. It leaves the address stack unchanged. One cycle after the operation, fault_valid is 1 and fault_code holds the code. Whenever fault_valid is 0, fault_code reads 0.
- R10: An address underflow (code 3) or address overflow (code 4) leaves both depths and all stack contents unchanged, and reports the code as in R9.
- R11: When one operation breaks several limits, the lowest code is reported and only its recovery applies. A data fault therefore takes precedence over an address fault.
- R12: clear empties both stacks on the next edge. It overrides any operation presented in the same cycle, and that operation raises no fault.
- R13: Opcode 0 (no-op), or any cycle with op_valid low, leaves both stacks unchanged and raises no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Empty both stacks |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation code (0 to 7) |
| push_val | input | WIDTH | Literal value for opcode 1 |
| d_top | output | WIDTH | Data stack top, 0 when empty |
| d_next | output | WIDTH | Second data entry, 0 when fewer than two |
| a_top | output | WIDTH | Address stack top, 0 when empty |
| a_next | output | WIDTH | Second address entry, 0 when fewer than two |
| d_depth | output | clog2(DATA_DEPTH+1) | Data stack depth |
| a_depth | output | clog2(ADDR_DEPTH+1) | Address stack depth |
| fault_valid | output | 1 | One-cycle fault pulse |
| fault_code | output | 4 | Fault code 1..4, otherwise 0 |

## Verification
The bench builds the block with DATA_DEPTH=4 and ADDR_DEPTH=3 and keeps WIDTH at 32. Both stacks can then be filled in a few operations, so every guard limit is within reach of short directed sequences. These include overflow by duplicate and by depth query, underflow on an empty stack, and a move that breaks a data limit and an address limit at once. The small address depth also has a non-power-of-two size, which exercises the index slicing in the storage.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_LIT   = 3'd1,
    OP_DUP   = 3'd2,
    OP_DROP  = 3'd3,
    OP_SWAP  = 3'd4,
    OP_TOA   = 3'd5,
    OP_FROMA = 3'd6,
    OP_DEPTH = 3'd7
  } tsg_op_e;

  // operands required and peak growth, per stack
  typedef struct packed {
    logic [1:0] d_need;
    logic [1:0] d_grow;
    logic       a_need;
    logic       a_grow;
  } tsg_demand_t;

  localparam logic [3:0] FC_NONE    = 4'd0;
  localparam logic [3:0] FC_D_UNDER = 4'd1;
  localparam logic [3:0] FC_D_OVER  = 4'd2;
  localparam logic [3:0] FC_A_UNDER = 4'd3;
  localparam logic [3:0] FC_A_OVER  = 4'd4;

  function automatic tsg_demand_t op_demand(tsg_op_e op);
    tsg_demand_t d;
    d = '0;
    case (op)
      OP_LIT:   d.d_grow = 2'd1;
      OP_DUP:   begin d.d_need = 2'd1; d.d_grow = 2'd1; end
      OP_DROP:  d.d_need = 2'd1;
      OP_SWAP:  d.d_need = 2'd2;
      OP_TOA:   begin d.d_need = 2'd1; d.a_grow = 1'b1; end
      OP_FROMA: begin d.a_need = 1'b1; d.d_grow = 2'd1; end
      OP_DEPTH: d.d_grow = 2'd2;
      default:  d = '0;
    endcase
    return d;
  endfunction

  // lowest code wins
  function automatic logic [3:0] pick_fault(logic du, logic dov, logic au, logic aov);
    if (du)       return FC_D_UNDER;
    else if (dov) return FC_D_OVER;
    else if (au)  return FC_A_UNDER;
    else if (aov) return FC_A_OVER;
    return FC_NONE;
  endfunction

endpackage

// File: rtl/tsg_lifo.sv
module tsg_lifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int PW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [PW-1:0]    new_depth,
  input  logic             we0,
  input  logic [PW-1:0]    idx0,
  input  logic [WIDTH-1:0] dat0,
  input  logic             we1,
  input  logic [PW-1:0]    idx1,
  input  logic [WIDTH-1:0] dat1,
  output logic [PW-1:0]    depth,
  output logic [WIDTH-1:0] top,
  output logic [WIDTH-1:0] next
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) depth <= '0;
    else if (ld) depth <= new_depth;
  end

  always_ff @(posedge clk) begin
    if (we0) mem[IW'(idx0)] <= dat0;
    if (we1) mem[IW'(idx1)] <= dat1;
  end

  always_comb begin
    top  = (depth != '0) ? mem[IW'(depth - PW'(1))] : '0;
    next = (depth > PW'(1)) ? mem[IW'(depth - PW'(2))] : '0;
  end

endmodule

// File: rtl/tsg_guard.sv
module tsg_guard
  import tsg_pkg::*;
#(
  parameter int DATA_DEPTH = 32,
  parameter int ADDR_DEPTH = 256,
  localparam int DPW = $clog2(DATA_DEPTH + 1),
  localparam int APW = $clog2(ADDR_DEPTH + 1)
) (
  input  tsg_op_e        op,
  input  logic [DPW-1:0] d_depth,
  input  logic [APW-1:0] a_depth,
  output logic           d_under,
  output logic           d_over,
  output logic           a_under,
  output logic           a_over
);

  tsg_demand_t dem;

  always_comb begin
    dem     = op_demand(op);
    d_under = int'(d_depth) < int'(dem.d_need);
    d_over  = (int'(d_depth) + int'(dem.d_grow)) > DATA_DEPTH;
    a_under = int'(a_depth) < int'(dem.a_need);
    a_over  = (int'(a_depth) + int'(dem.a_grow)) > ADDR_DEPTH;
  end

endmodule

// File: rtl/tsg_ctrl.sv
module tsg_ctrl
  import tsg_pkg::*;
#(
  parameter int DATA_DEPTH = 32,
  parameter int ADDR_DEPTH = 256,
  parameter int WIDTH = 32,
  localparam int DPW = $clog2(DATA_DEPTH + 1),
  localparam int APW = $clog2(ADDR_DEPTH + 1)
) (
  input  logic             clear,
  input  logic             op_valid,
  input  tsg_op_e          op,
  input  logic [WIDTH-1:0] push_val,
  input  logic [DPW-1:0]   d_depth,
  input  logic [APW-1:0]   a_depth,
  input  logic [WIDTH-1:0] d_top,
  input  logic [WIDTH-1:0] d_next,
  input  logic [WIDTH-1:0] a_top,
  input  logic             d_under,
  input  logic             d_over,
  input  logic             a_under,
  input  logic             a_over,
  output logic             d_ld,
  output logic [DPW-1:0]   d_new,
  output logic             d_we0,
  output logic [DPW-1:0]   d_idx0,
  output logic [WIDTH-1:0] d_dat0,
  output logic             d_we1,
  output logic [DPW-1:0]   d_idx1,
  output logic [WIDTH-1:0] d_dat1,
  output logic             a_ld,
  output logic [APW-1:0]   a_new,
  output logic             a_we,
  output logic [APW-1:0]   a_idx,
  output logic [WIDTH-1:0] a_dat,
  output logic [3:0]       fault_nxt
);

  logic [3:0] fc;

  always_comb begin
    fc        = pick_fault(d_under, d_over, a_under, a_over);
    d_ld      = 1'b0;  d_new  = d_depth;
    d_we0     = 1'b0;  d_idx0 = d_depth;  d_dat0 = '0;
    d_we1     = 1'b0;  d_idx1 = d_depth;  d_dat1 = '0;
    a_ld      = 1'b0;  a_new  = a_depth;
    a_we      = 1'b0;  a_idx  = a_depth;  a_dat  = '0;
    fault_nxt = FC_NONE;
    if (clear) begin
      d_ld  = 1'b1;  d_new = '0;
      a_ld  = 1'b1;  a_new = '0;
    end else if (op_valid) begin
      fault_nxt = fc;
      if (fc == FC_D_UNDER || fc == FC_D_OVER) begin
        d_ld  = 1'b1;
        d_new = '0;
      end else if (fc == FC_NONE) begin
        case (op)
          OP_LIT: begin
            d_we0 = 1'b1;  d_dat0 = push_val;
            d_ld  = 1'b1;  d_new  = d_depth + DPW'(1);
          end
          OP_DUP: begin
            d_we0 = 1'b1;  d_dat0 = d_top;
            d_ld  = 1'b1;  d_new  = d_depth + DPW'(1);
          end
          OP_DROP: begin
            d_ld  = 1'b1;  d_new  = d_depth - DPW'(1);
          end
          OP_SWAP: begin
            d_we0 = 1'b1;  d_idx0 = d_depth - DPW'(1);  d_dat0 = d_next;
            d_we1 = 1'b1;  d_idx1 = d_depth - DPW'(2);  d_dat1 = d_top;
          end
          OP_TOA: begin
            a_we  = 1'b1;  a_dat  = d_top;
            a_ld  = 1'b1;  a_new  = a_depth + APW'(1);
            d_ld  = 1'b1;  d_new  = d_depth - DPW'(1);
          end
          OP_FROMA: begin
            d_we0 = 1'b1;  d_dat0 = a_top;
            d_ld  = 1'b1;  d_new  = d_depth + DPW'(1);
            a_ld  = 1'b1;  a_new  = a_depth - APW'(1);
          end
          OP_DEPTH: begin
            d_we0 = 1'b1;  d_dat0 = WIDTH'(d_depth);
            d_we1 = 1'b1;  d_idx1 = d_depth + DPW'(1);  d_dat1 = WIDTH'(a_depth);
            d_ld  = 1'b1;  d_new  = d_depth + DPW'(2);
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/tsg_unit.sv
module tsg_unit
  import tsg_pkg::*;
#(
  parameter int DATA_DEPTH = 32,
  parameter int ADDR_DEPTH = 256,
  parameter int WIDTH = 32,
  localparam int DPW = $clog2(DATA_DEPTH + 1),
  localparam int APW = $clog2(ADDR_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [WIDTH-1:0] push_val,
  output logic [WIDTH-1:0] d_top,
  output logic [WIDTH-1:0] d_next,
  output logic [WIDTH-1:0] a_top,
  output logic [WIDTH-1:0] a_next,
  output logic [DPW-1:0]   d_depth,
  output logic [APW-1:0]   a_depth,
  output logic             fault_valid,
  output logic [3:0]       fault_code
);

  tsg_op_e op_e;
  assign op_e = tsg_op_e'(op_code);

  // guard events, named for the checker
  logic d_under, d_over, a_under, a_over;

  logic             d_ld, d_we0, d_we1, a_ld, a_we;
  logic [DPW-1:0]   d_new, d_idx0, d_idx1;
  logic [APW-1:0]   a_new, a_idx;
  logic [WIDTH-1:0] d_dat0, d_dat1, a_dat;
  logic [3:0]       fault_nxt;

  tsg_guard #(.DATA_DEPTH(DATA_DEPTH), .ADDR_DEPTH(ADDR_DEPTH)) u_guard (
    .op(op_e), .d_depth(d_depth), .a_depth(a_depth),
    .d_under(d_under), .d_over(d_over), .a_under(a_under), .a_over(a_over)
  );

  tsg_ctrl #(.DATA_DEPTH(DATA_DEPTH), .ADDR_DEPTH(ADDR_DEPTH), .WIDTH(WIDTH)) u_ctrl (
    .clear(clear), .op_valid(op_valid), .op(op_e), .push_val(push_val),
    .d_depth(d_depth), .a_depth(a_depth),
    .d_top(d_top), .d_next(d_next), .a_top(a_top),
    .d_under(d_under), .d_over(d_over), .a_under(a_under), .a_over(a_over),
    .d_ld(d_ld), .d_new(d_new),
    .d_we0(d_we0), .d_idx0(d_idx0), .d_dat0(d_dat0),
    .d_we1(d_we1), .d_idx1(d_idx1), .d_dat1(d_dat1),
    .a_ld(a_ld), .a_new(a_new), .a_we(a_we), .a_idx(a_idx), .a_dat(a_dat),
    .fault_nxt(fault_nxt)
  );

  tsg_lifo #(.DEPTH(DATA_DEPTH), .WIDTH(WIDTH)) u_dstk (
    .clk(clk), .rst_n(rst_n), .ld(d_ld), .new_depth(d_new),
    .we0(d_we0), .idx0(d_idx0), .dat0(d_dat0),
    .we1(d_we1), .idx1(d_idx1), .dat1(d_dat1),
    .depth(d_depth), .top(d_top), .next(d_next)
  );

  tsg_lifo #(.DEPTH(ADDR_DEPTH), .WIDTH(WIDTH)) u_astk (
    .clk(clk), .rst_n(rst_n), .ld(a_ld), .new_depth(a_new),
    .we0(a_we), .idx0(a_idx), .dat0(a_dat),
    .we1(1'b0), .idx1('0), .dat1('0),
    .depth(a_depth), .top(a_top), .next(a_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_valid <= 1'b0;
      fault_code  <= FC_NONE;
    end else begin
      fault_valid <= (fault_nxt != FC_NONE);
      fault_code  <= fault_nxt;
    end
  end

endmodule

// File: rtl/tsg_unit_chk.sv
module tsg_unit_chk #(
  parameter int DATA_DEPTH = 32,
  parameter int ADDR_DEPTH = 256,
  localparam int DPW = $clog2(DATA_DEPTH + 1),
  localparam int APW = $clog2(ADDR_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           clear,
  input logic           op_valid,
  input logic           d_under,
  input logic           a_under,
  input logic [DPW-1:0] d_depth,
  input logic [APW-1:0] a_depth,
  input logic           fault_valid,
  input logic [3:0]     fault_code
);

  // R9
  data_fault_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && (fault_code == 4'd1 || fault_code == 4'd2) |-> d_depth == '0);

  // R10
  addr_fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && (fault_code == 4'd3 || fault_code == 4'd4) |-> $stable(a_depth) && $stable(d_depth));

  // R9
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> fault_code >= 4'd1 && fault_code <= 4'd4);

  // R9
  code_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_valid |-> fault_code == 4'd0);

  // R12
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> d_depth == '0 && a_depth == '0 && !fault_valid);

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid && !clear |=> $stable(d_depth) && $stable(a_depth) && !fault_valid);

  // R11
  data_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !clear && d_under |=> fault_code == 4'd1);

  // R11
  addr_under_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !clear && a_under && !d_under |=> fault_valid && fault_code <= 4'd3);

  // R9
  d_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_depth <= DPW'(DATA_DEPTH));

  // R10
  a_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_depth <= APW'(ADDR_DEPTH));

endmodule

bind tsg_unit tsg_unit_chk #(.DATA_DEPTH(DATA_DEPTH), .ADDR_DEPTH(ADDR_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .op_valid(op_valid),
  .d_under(d_under), .a_under(a_under),
  .d_depth(d_depth), .a_depth(a_depth),
  .fault_valid(fault_valid), .fault_code(fault_code)
);

// File: tb/tsg_unit_tb.sv
module tsg_unit_tb;

  localparam int DD = 4;
  localparam int AD = 3;
  localparam int W  = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clear = 1'b0;
  logic          op_valid = 1'b0;
  logic [2:0]    op_code = 3'd0;
  logic [W-1:0]  push_val = '0;
  logic [W-1:0]  d_top, d_next, a_top, a_next;
  logic [$clog2(DD+1)-1:0] d_depth;
  logic [$clog2(AD+1)-1:0] a_depth;
  logic          fault_valid;
  logic [3:0]    fault_code;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tsg_unit #(.DATA_DEPTH(DD), .ADDR_DEPTH(AD), .WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .op_valid(op_valid),
    .op_code(op_code), .push_val(push_val),
    .d_top(d_top), .d_next(d_next), .a_top(a_top), .a_next(a_next),
    .d_depth(d_depth), .a_depth(a_depth),
    .fault_valid(fault_valid), .fault_code(fault_code)
  );

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // state check: depths, tops, fault
  task automatic st(string tag, int dd, int dt, int dn, int ad, int at, int fv, int fc);
    chk({tag, " d_depth"}, int'(d_depth), dd);
    chk({tag, " d_top"}, int'(d_top), dt);
    chk({tag, " d_next"}, int'(d_next), dn);
    chk({tag, " a_depth"}, int'(a_depth), ad);
    chk({tag, " a_top"}, int'(a_top), at);
    chk({tag, " fault_valid"}, int'(fault_valid), fv);
    chk({tag, " fault_code"}, int'(fault_code), fc);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic run_op(logic [2:0] op, int v, logic clr = 1'b0, logic vld = 1'b1);
    op_code  = op;
    push_val = W'(v);
    op_valid = vld;
    clear    = clr;
    @(negedge clk);
    op_valid = 1'b0;
    clear    = 1'b0;
  endtask

  task automatic t_reset();
    st("R1 reset", 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_basic();
    run_op(3'd1, 11); run_op(3'd1, 22); run_op(3'd1, 33);
    st("R2 literal", 3, 33, 22, 0, 0, 0, 0);
    run_op(3'd2, 0);
    st("R3 duplicate", 4, 33, 33, 0, 0, 0, 0);
    run_op(3'd3, 0);
    st("R4 drop", 3, 33, 22, 0, 0, 0, 0);
    run_op(3'd4, 0);
    st("R5 swap", 3, 22, 33, 0, 0, 0, 0);
  endtask

  task automatic t_data_faults();
    run_op(3'd2, 0);
    run_op(3'd2, 0);
    st("R9 data overflow", 0, 0, 0, 0, 0, 1, 2);
    run_op(3'd0, 0, 1'b0, 1'b0);
    st("R9 pulse ends", 0, 0, 0, 0, 0, 0, 0);
    run_op(3'd3, 0);
    st("R9 data underflow", 0, 0, 0, 0, 0, 1, 1);
    run_op(3'd4, 0);
    st("R9 swap on empty", 0, 0, 0, 0, 0, 1, 1);
  endtask

  task automatic t_moves();
    run_op(3'd1, 5); run_op(3'd1, 7);
    run_op(3'd5, 0);
    st("R6 to address", 1, 5, 0, 1, 7, 0, 0);
    run_op(3'd6, 0);
    st("R7 from address", 2, 7, 5, 0, 0, 0, 0);
    run_op(3'd6, 0);
    st("R10 address underflow", 2, 7, 5, 0, 0, 1, 3);
    run_op(3'd5, 0); run_op(3'd5, 0);
    run_op(3'd1, 1); run_op(3'd5, 0);
    st("R6 address full", 0, 0, 0, 3, 1, 0, 0);
    chk("R6 a_next", int'(a_next), 5);
    run_op(3'd1, 9);
    run_op(3'd5, 0);
    st("R10 address overflow", 1, 9, 0, 3, 1, 1, 4);
    chk("R10 a_next kept", int'(a_next), 5);
    run_op(3'd3, 0);
    run_op(3'd5, 0);
    st("R11 data beats address", 0, 0, 0, 3, 1, 1, 1);
  endtask

  task automatic t_depth();
    run_op(3'd7, 0);
    st("R8 depth query", 2, 3, 0, 3, 1, 0, 0);
    run_op(3'd7, 0);
    st("R8 second query", 4, 3, 2, 3, 1, 0, 0);
    run_op(3'd7, 0);
    st("R9 query overflow", 0, 0, 0, 3, 1, 1, 2);
  endtask

  task automatic t_clear_idle();
    run_op(3'd1, 4);
    run_op(3'd1, 8, 1'b1);
    st("R12 clear wins", 0, 0, 0, 0, 0, 0, 0);
    run_op(3'd3, 0, 1'b1);
    st("R12 clear no fault", 0, 0, 0, 0, 0, 0, 0);
    run_op(3'd1, 6);
    run_op(3'd0, 0);
    st("R13 no-op", 1, 6, 0, 0, 0, 0, 0);
    run_op(3'd1, 99, 1'b0, 1'b0);
    st("R13 strobe low", 1, 6, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_data_faults();
    t_moves();
    t_depth();
    t_clear_idle();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule